// File: doc/BRIEF.md
# Address Violation Capture Unit

This unit sits beside the address table of a switch and records the first address-table violation that the forwarding path reports. A violation arrives as a single-cycle strobe. The strobe carries a set of type flags, the source port id, the port vector, the 48-bit MAC address and the database number of the offending access. The first strobe is latched and raises an interrupt. The details stay held until the host collects them.

The host collects a violation through the operation register. It writes the busy bit together with the get-and-clear opcode. For a programmable number of cycles the unit reports busy. In the final cycle it copies the held violation into the readable flag, data, MAC and database registers, drops the hold and clears busy. The source port id is returned in the entry-state field of the data register. The port vector sits directly above it, in the same layout that a normal table entry uses.

While a violation is held, later strobes are not recorded. When the overflow option is built in, such a strobe sets a sticky bit, and that bit is returned with the next fetch.

Top module: `avc_unit`

## Requirements
- R1: After reset, irq_o, busy_o, vovf_o, vflags_o, data_o, mac_o and db_o are all zero.
- R2: A strobe on viol_valid_i while nothing is held is latched, and irq_o is high from the next cycle on.
- R3: While a violation is held, later strobes leave the held details unchanged, so the next fetch returns the first violation. With OVF_EN=1 such a strobe makes the fetch return vovf_o=1. With OVF_EN=0, vovf_o stays 0.
- R4: A write with host_wr_i=1, host_busy_i=1 and host_opcode_i=3'b111 (get-and-clear) holds busy_o high for exactly FETCH_CYCLES cycles. The following writes are ignored: writes with host_busy_i=0, writes with any other opcode, and writes made while busy_o is high. An ignored write leaves busy_o low, or keeps the running busy period at its length, and changes no readable register.
- R5: At the end of a fetch, vflags_o shows the type flags of the held strobe. The bit positions are: bit 0 member, bit 1 miss, bit 2 table full, bit 3 age-out. Several bits may be set together.
- R6: At the end of a fetch, data_o[3:0] holds the source port id and data_o[4 +: PORTS] holds the port vector. mac_o holds the MAC address and db_o holds the database number.
- R7: irq_o is low from the cycle after the fetch completes, unless a new strobe arrived in the completion cycle.
- R8: A fetch issued while nothing is held returns vflags_o=0, vovf_o=0, data_o=0, mac_o=0 and db_o=0.
- R9: A strobe arriving in the cycle in which a fetch completes is latched as a new violation. irq_o stays high and the fetch returns the previous violation.
- R10: The readable registers change only when a fetch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| viol_valid_i | input | 1 | Single-cycle violation strobe |
| viol_kind_i | input | 4 | Violation type flags (member, miss, full, age-out) |
| viol_spid_i | input | 4 | Source port id of the violating frame |
| viol_portvec_i | input | PORTS | Port vector of the violating access |
| viol_mac_i | input | 48 | MAC address of the violating access |
| viol_db_i | input | DB_W | Database number of the violating access |
| host_wr_i | input | 1 | Host write strobe to the operation register |
| host_busy_i | input | 1 | Busy bit of the written operation value |
| host_opcode_i | input | 3 | Opcode of the written operation value |
| busy_o | output | 1 | Operation in progress |
| irq_o | output | 1 | Violation pending |
| vflags_o | output | 4 | Fetched violation type flags |
| vovf_o | output | 1 | Fetched overflow flag |
| data_o | output | 4+PORTS | Fetched data register: port id and port vector |
| mac_o | output | 48 | Fetched MAC address |
| db_o | output | DB_W | Fetched database number |

## Verification
The bench builds the unit with FETCH_CYCLES=3, PORTS=7 and DB_W=8. A busy period of three cycles leaves room to aim a violation strobe exactly at the completion cycle and to write a second command halfway through a fetch. Two instances are driven from the same inputs, one with OVF_EN=1 and one with OVF_EN=0. This exercises both generate variants of the overflow bit under identical traffic. The narrow port vector and database fields let the bench use distinct, easily checked patterns in every field.

// File: rtl/avc_pkg.sv
package avc_pkg;
  localparam int unsigned SPID_W = 4;
  localparam int unsigned KIND_W = 4;
  localparam int unsigned MAC_W  = 48;
  localparam int unsigned OPC_W  = 3;

  localparam logic [OPC_W-1:0] OPC_GET_CLR = 3'b111;

  // kind flag positions
  localparam int unsigned K_MEMBER = 0;
  localparam int unsigned K_MISS   = 1;
  localparam int unsigned K_FULL   = 2;
  localparam int unsigned K_AGE    = 3;
endpackage

// File: rtl/avc_capture.sv
module avc_capture
  import avc_pkg::*;
#(
  parameter int unsigned PORTS  = 11,
  parameter int unsigned DB_W   = 12,
  parameter bit          OVF_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [SPID_W-1:0] spid_i,
  input  logic [PORTS-1:0]  portvec_i,
  input  logic [MAC_W-1:0]  mac_i,
  input  logic [DB_W-1:0]   db_i,
  input  logic              clear_i,
  output logic              held_o,
  output logic              ovf_o,
  output logic [KIND_W-1:0] kind_o,
  output logic [SPID_W-1:0] spid_o,
  output logic [PORTS-1:0]  portvec_o,
  output logic [MAC_W-1:0]  mac_o,
  output logic [DB_W-1:0]   db_o
);
  logic held_q;
  logic take;

  // a free slot, or one being released this cycle, accepts the strobe
  assign take = valid_i & (~held_q | clear_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
    end else if (clear_i) begin
      held_q <= valid_i;
    end else if (valid_i) begin
      held_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o    <= '0;
      spid_o    <= '0;
      portvec_o <= '0;
      mac_o     <= '0;
      db_o      <= '0;
    end else if (take) begin
      kind_o    <= kind_i;
      spid_o    <= spid_i;
      portvec_o <= portvec_i;
      mac_o     <= mac_i;
      db_o      <= db_i;
    end
  end

  generate
    if (OVF_EN) begin : g_ovf
      logic ovf_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ovf_q <= 1'b0;
        end else if (clear_i) begin
          ovf_q <= 1'b0;
        end else if (held_q && valid_i) begin
          ovf_q <= 1'b1;
        end
      end
      assign ovf_o = ovf_q;
    end else begin : g_no_ovf
      assign ovf_o = 1'b0;
    end
  endgenerate

  assign held_o = held_q;
endmodule

// File: rtl/avc_cmd.sv
module avc_cmd
  import avc_pkg::*;
#(
  parameter int unsigned FETCH_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             busy_bit_i,
  input  logic [OPC_W-1:0] opcode_i,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned CNT_W = $clog2(FETCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FETCH_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start;

  assign start  = wr_i & busy_bit_i & (opcode_i == OPC_GET_CLR) & ~busy_q;
  assign done_o = busy_q & (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_LOAD;
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - CNT_LAST;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/avc_readout.sv
module avc_readout
  import avc_pkg::*;
#(
  parameter int unsigned PORTS = 11,
  parameter int unsigned DB_W  = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    held_i,
  input  logic                    ovf_i,
  input  logic [KIND_W-1:0]       kind_i,
  input  logic [SPID_W-1:0]       spid_i,
  input  logic [PORTS-1:0]        portvec_i,
  input  logic [MAC_W-1:0]        mac_i,
  input  logic [DB_W-1:0]         db_i,
  output logic [KIND_W-1:0]       flags_o,
  output logic                    ovf_o,
  output logic [SPID_W+PORTS-1:0] data_o,
  output logic [MAC_W-1:0]        mac_o,
  output logic [DB_W-1:0]         db_o
);
  logic [SPID_W+PORTS-1:0] data_d;

  // entry layout: state field low, port vector above it
  assign data_d = {portvec_i, spid_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      ovf_o   <= 1'b0;
      data_o  <= '0;
      mac_o   <= '0;
      db_o    <= '0;
    end else if (load_i) begin
      flags_o <= held_i ? kind_i : '0;
      ovf_o   <= held_i & ovf_i;
      data_o  <= held_i ? data_d : '0;
      mac_o   <= held_i ? mac_i  : '0;
      db_o    <= held_i ? db_i   : '0;
    end
  end
endmodule

// File: rtl/avc_unit.sv
module avc_unit
  import avc_pkg::*;
#(
  parameter int unsigned FETCH_CYCLES = 4,
  parameter int unsigned PORTS        = 11,
  parameter int unsigned DB_W         = 12,
  parameter bit          OVF_EN       = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    viol_valid_i,
  input  logic [KIND_W-1:0]       viol_kind_i,
  input  logic [SPID_W-1:0]       viol_spid_i,
  input  logic [PORTS-1:0]        viol_portvec_i,
  input  logic [MAC_W-1:0]        viol_mac_i,
  input  logic [DB_W-1:0]         viol_db_i,
  input  logic                    host_wr_i,
  input  logic                    host_busy_i,
  input  logic [OPC_W-1:0]        host_opcode_i,
  output logic                    busy_o,
  output logic                    irq_o,
  output logic [KIND_W-1:0]       vflags_o,
  output logic                    vovf_o,
  output logic [SPID_W+PORTS-1:0] data_o,
  output logic [MAC_W-1:0]        mac_o,
  output logic [DB_W-1:0]         db_o
);
  logic              done;
  logic              held;
  logic              ovf;
  logic [KIND_W-1:0] h_kind;
  logic [SPID_W-1:0] h_spid;
  logic [PORTS-1:0]  h_portvec;
  logic [MAC_W-1:0]  h_mac;
  logic [DB_W-1:0]   h_db;

  avc_cmd #(.FETCH_CYCLES(FETCH_CYCLES)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (host_wr_i),
    .busy_bit_i (host_busy_i),
    .opcode_i   (host_opcode_i),
    .busy_o     (busy_o),
    .done_o     (done)
  );

  avc_capture #(.PORTS(PORTS), .DB_W(DB_W), .OVF_EN(OVF_EN)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (viol_valid_i),
    .kind_i    (viol_kind_i),
    .spid_i    (viol_spid_i),
    .portvec_i (viol_portvec_i),
    .mac_i     (viol_mac_i),
    .db_i      (viol_db_i),
    .clear_i   (done),
    .held_o    (held),
    .ovf_o     (ovf),
    .kind_o    (h_kind),
    .spid_o    (h_spid),
    .portvec_o (h_portvec),
    .mac_o     (h_mac),
    .db_o      (h_db)
  );

  avc_readout #(.PORTS(PORTS), .DB_W(DB_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (done),
    .held_i    (held),
    .ovf_i     (ovf),
    .kind_i    (h_kind),
    .spid_i    (h_spid),
    .portvec_i (h_portvec),
    .mac_i     (h_mac),
    .db_i      (h_db),
    .flags_o   (vflags_o),
    .ovf_o     (vovf_o),
    .data_o    (data_o),
    .mac_o     (mac_o),
    .db_o      (db_o)
  );

  assign irq_o = held;
endmodule

// File: rtl/avc_unit_chk.sv
module avc_unit_chk
  import avc_pkg::*;
#(
  parameter int unsigned PORTS  = 11,
  parameter int unsigned DB_W   = 12,
  parameter bit          OVF_EN = 1'b1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    viol_valid_i,
  input logic                    host_wr_i,
  input logic                    host_busy_i,
  input logic [OPC_W-1:0]        host_opcode_i,
  input logic                    busy_o,
  input logic                    irq_o,
  input logic [KIND_W-1:0]       vflags_o,
  input logic                    vovf_o,
  input logic [SPID_W+PORTS-1:0] data_o,
  input logic [MAC_W-1:0]        mac_o,
  input logic [DB_W-1:0]         db_o
);
  logic go;
  assign go = host_wr_i & host_busy_i & (host_opcode_i == OPC_GET_CLR);

  p_irq_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && viol_valid_i) |=> irq_o);

  p_no_ovf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vovf_o |-> OVF_EN);

  p_idle_ignore_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !go) |=> !busy_o);

  p_irq_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(viol_valid_i)) |-> !irq_o);

  p_empty_fetch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(irq_o)) |-> (vflags_o == '0 && data_o == '0 && mac_o == '0 && db_o == '0));

  p_regs_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_o) |-> ($stable(vflags_o) && $stable(vovf_o) && $stable(data_o)
                        && $stable(mac_o) && $stable(db_o)));
endmodule

bind avc_unit avc_unit_chk #(.PORTS(PORTS), .DB_W(DB_W), .OVF_EN(OVF_EN)) u_chk (.*);

// File: tb/avc_unit_test.sv
module avc_unit_test;
  localparam int unsigned FC    = 3;
  localparam int unsigned PORTS = 7;
  localparam int unsigned DB_W  = 8;
  localparam int unsigned DW    = 4 + PORTS;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            viol_valid_i = 1'b0;
  logic [3:0]      viol_kind_i = '0;
  logic [3:0]      viol_spid_i = '0;
  logic [PORTS-1:0] viol_portvec_i = '0;
  logic [47:0]     viol_mac_i = '0;
  logic [DB_W-1:0] viol_db_i = '0;
  logic            host_wr_i = 1'b0;
  logic            host_busy_i = 1'b0;
  logic [2:0]      host_opcode_i = '0;

  logic            busy_o, irq_o, vovf_o;
  logic [3:0]      vflags_o;
  logic [DW-1:0]   data_o;
  logic [47:0]     mac_o;
  logic [DB_W-1:0] db_o;

  logic            nb_busy, nb_irq, nb_ovf;
  logic [3:0]      nb_flags;
  logic [DW-1:0]   nb_data;
  logic [47:0]     nb_mac;
  logic [DB_W-1:0] nb_db;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  avc_unit #(.FETCH_CYCLES(FC), .PORTS(PORTS), .DB_W(DB_W), .OVF_EN(1'b1)) uut (
    .clk_i, .rst_ni, .viol_valid_i, .viol_kind_i, .viol_spid_i, .viol_portvec_i,
    .viol_mac_i, .viol_db_i, .host_wr_i, .host_busy_i, .host_opcode_i,
    .busy_o, .irq_o, .vflags_o, .vovf_o, .data_o, .mac_o, .db_o
  );

  avc_unit #(.FETCH_CYCLES(FC), .PORTS(PORTS), .DB_W(DB_W), .OVF_EN(1'b0)) uut_novf (
    .clk_i, .rst_ni, .viol_valid_i, .viol_kind_i, .viol_spid_i, .viol_portvec_i,
    .viol_mac_i, .viol_db_i, .host_wr_i, .host_busy_i, .host_opcode_i,
    .busy_o(nb_busy), .irq_o(nb_irq), .vflags_o(nb_flags), .vovf_o(nb_ovf),
    .data_o(nb_data), .mac_o(nb_mac), .db_o(nb_db)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [3:0] k, input logic [3:0] sp, input logic [PORTS-1:0] pv,
                        input logic [47:0] m, input logic [DB_W-1:0] d);
    @(negedge clk_i);
    viol_valid_i = 1'b1; viol_kind_i = k; viol_spid_i = sp;
    viol_portvec_i = pv; viol_mac_i = m; viol_db_i = d;
    @(negedge clk_i);
    viol_valid_i = 1'b0;
  endtask

  // issue a host write, return number of busy cycles seen
  task automatic host_write(input logic bb, input logic [2:0] opc, output int busy_cnt);
    @(negedge clk_i);
    host_wr_i = 1'b1; host_busy_i = bb; host_opcode_i = opc;
    @(negedge clk_i);
    host_wr_i = 1'b0; host_busy_i = 1'b0; host_opcode_i = '0;
    busy_cnt = 0;
    while (busy_o && busy_cnt < 50) begin
      busy_cnt++;
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset;
    check("R1 irq", irq_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 ovf", vovf_o, 0);
    check("R1 flags", vflags_o, 0);
    check("R1 data", data_o, 0);
    check("R1 mac", mac_o, 0);
    check("R1 db", db_o, 0);
  endtask

  task automatic t_single;
    int n;
    strobe(4'b0001, 4'd5, 7'h2A, 48'h0011_2233_4455, 8'h3C);
    check("R2 irq after strobe", irq_o, 1);
    check("R10 regs before fetch", data_o, 0);
    host_write(1'b1, 3'b111, n);
    check("R4 busy length", n, FC);
    check("R5 member flag", vflags_o, 4'b0001);
    check("R6 data spid+portvec", data_o, {7'h2A, 4'd5});
    check("R6 mac", mac_o, 48'h0011_2233_4455);
    check("R6 db", db_o, 8'h3C);
    check("R7 irq cleared", irq_o, 0);
    check("R3 no ovf", vovf_o, 0);
  endtask

  task automatic t_multi_kind;
    int n;
    strobe(4'b1010, 4'd15, 7'h7F, 48'hFFEE_DDCC_BBAA, 8'hFF);
    host_write(1'b1, 3'b111, n);
    check("R5 miss+age flags", vflags_o, 4'b1010);
    check("R6 data max fields", data_o, {7'h7F, 4'd15});
    check("R6 mac", mac_o, 48'hFFEE_DDCC_BBAA);
    strobe(4'b0100, 4'd0, 7'h01, 48'h1, 8'h01);
    host_write(1'b1, 3'b111, n);
    check("R5 full flag", vflags_o, 4'b0100);
    check("R6 spid zero", data_o, {7'h01, 4'd0});
  endtask

  task automatic t_hold_first;
    int n;
    strobe(4'b0001, 4'd3, 7'h11, 48'hA1A1_A1A1_A1A1, 8'h11);
    strobe(4'b0100, 4'd9, 7'h22, 48'hB2B2_B2B2_B2B2, 8'h22);
    check("R3 irq still high", irq_o, 1);
    check("R10 regs unchanged by strobe", vflags_o, 4'b0100);
    host_write(1'b1, 3'b111, n);
    check("R3 first flags kept", vflags_o, 4'b0001);
    check("R3 first data kept", data_o, {7'h11, 4'd3});
    check("R3 first mac kept", mac_o, 48'hA1A1_A1A1_A1A1);
    check("R3 overflow set", vovf_o, 1);
    check("R3 no overflow when disabled", nb_ovf, 0);
    check("R3 disabled variant first data", nb_data, {7'h11, 4'd3});
    host_write(1'b1, 3'b111, n);
    check("R8 overflow cleared", vovf_o, 0);
  endtask

  task automatic t_ignored;
    int n;
    strobe(4'b0010, 4'd6, 7'h05, 48'h0000_0000_0606, 8'h66);
    host_write(1'b1, 3'b101, n);
    check("R4 wrong opcode no busy", n, 0);
    check("R4 wrong opcode irq kept", irq_o, 1);
    check("R4 wrong opcode regs kept", vflags_o, 0);
    host_write(1'b0, 3'b111, n);
    check("R4 busy bit clear no busy", n, 0);
    check("R4 busy bit clear regs kept", data_o, 0);
    host_write(1'b1, 3'b111, n);
    check("R5 after ignored writes", vflags_o, 4'b0010);
    check("R6 db", db_o, 8'h66);
  endtask

  task automatic t_write_in_busy;
    int n;
    @(negedge clk_i);
    host_wr_i = 1'b1; host_busy_i = 1'b1; host_opcode_i = 3'b111;
    @(negedge clk_i);
    @(negedge clk_i);
    host_wr_i = 1'b0; host_busy_i = 1'b0; host_opcode_i = '0;
    n = 1;
    while (busy_o && n < 50) begin
      n++;
      @(negedge clk_i);
    end
    check("R4 write while busy ignored", n, FC);
  endtask

  task automatic t_empty;
    int n;
    host_write(1'b1, 3'b111, n);
    check("R8 empty flags", vflags_o, 0);
    check("R8 empty data", data_o, 0);
    check("R8 empty mac", mac_o, 0);
    check("R8 empty db", db_o, 0);
    check("R8 empty ovf", vovf_o, 0);
  endtask

  task automatic t_collide;
    strobe(4'b0001, 4'd7, 7'h33, 48'h0101_0101_0101, 8'h77);
    @(negedge clk_i);
    host_wr_i = 1'b1; host_busy_i = 1'b1; host_opcode_i = 3'b111;
    @(negedge clk_i);
    host_wr_i = 1'b0; host_busy_i = 1'b0; host_opcode_i = '0;
    repeat (FC - 1) @(negedge clk_i);
    viol_valid_i = 1'b1; viol_kind_i = 4'b1000; viol_spid_i = 4'd2;
    viol_portvec_i = 7'h44; viol_mac_i = 48'h0202_0202_0202; viol_db_i = 8'h88;
    @(negedge clk_i);
    viol_valid_i = 1'b0;
    check("R9 busy done", busy_o, 0);
    check("R9 irq stays high", irq_o, 1);
    check("R9 old violation fetched", vflags_o, 4'b0001);
    check("R9 old data fetched", data_o, {7'h33, 4'd7});
    check("R9 no ovf", vovf_o, 0);
    begin
      int n;
      host_write(1'b1, 3'b111, n);
    end
    check("R9 new violation fetched", vflags_o, 4'b1000);
    check("R9 new db fetched", db_o, 8'h88);
    check("R7 irq low after", irq_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_single();
    t_multi_kind();
    t_hold_first();
    t_ignored();
    t_write_in_busy();
    t_empty();
    t_collide();
    repeat (3) @(negedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule